// File: doc/BRIEF.md
# Coherency Conflict Resolution Controller

This block lives in the system-side agent of a cached processor. It resolves the collision between one outstanding processor coherent request and an external coherency request that arrives for the same cache block. The block holds one pending processor request, which is either a coherent block read or an upgrade. It accepts external conflicts of three kinds: intervention-shared, intervention-exclusive and invalidate.

For each accepted conflict the block picks one of two paths. On the direct path it returns a block state to the external requestor and does not involve the processor. On the forwarding path it passes the conflict to the processor. It then waits for the processor's coherency state response, and only after that does it send a completion acknowledgement. The block also watches the response that finally retires the pending request. It raises an error pulse when that response breaks the rules that the conflict set up.

A run-time option sends every conflict down the forwarding path. This includes the cases that the direct path would normally answer. A parameter can remove this option at elaboration.

Top module: `ccr_resolver`

## Requirements
- R1: After reset no request is pending and every output is 0. Pending kinds are 2'b01 block read and 2'b10 upgrade. Conflict kinds are 2'b01 intervention-shared, 2'b10 intervention-exclusive and 2'b11 invalidate; kind 2'b00 is never accepted. Block states are 2'b00 Invalid and 2'b01 Shared.
- R2: With a block read pending, a conflict of any kind accepted on edge N gives `direct_valid_o`=1 with state Invalid for the one cycle after N. No forward is issued.
- R3: With an upgrade pending, an intervention-shared conflict gives a one-cycle direct response with state Shared after the accepting edge. No forward is issued.
- R4: With an upgrade pending, an intervention-exclusive or invalidate conflict is not answered directly. `fwd_valid_o` pulses for one cycle after the accepting edge, and `fwd_kind_o` carries the conflict kind.
- R5: On a forwarded conflict, `ack_o` pulses exactly once. It comes in the cycle after the edge that samples `proc_state_valid_i`, and never before the state response, however late that response is.
- R6: Once an intervention-exclusive or invalidate conflict has been forwarded on a pending upgrade, a retiring response with `retire_data_i`=0 (plain ACK) raises `proto_err_o` for one cycle. A retiring response with data does not.
- R7: When `force_fwd_i`=1, every conflict is forwarded. The expected processor state is Invalid for a pending read and Shared for a pending upgrade. A different state raises `proto_err_o` in the cycle after it is sampled.
- R8: With nothing pending, a conflict gives no response, no forward and no busy indication.
- R9: A new conflict is accepted only while no resolution is in progress. Conflicts that arrive during a forward produce no second forward or response.
- R10: `pending_o` rises after an accepted `pend_valid_i` and falls after a retiring response. A retiring response that arrives while a resolution is in progress raises `proto_err_o`.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| force_fwd_i | input | 1 | Forward every conflict to the processor |
| pend_valid_i | input | 1 | A processor coherent request is issued |
| pend_kind_i | input | 2 | Kind of the issued request (read / upgrade) |
| retire_valid_i | input | 1 | External response retiring the pending request |
| retire_data_i | input | 1 | Retiring response carries block data |
| cf_valid_i | input | 1 | Conflicting external coherency request |
| cf_kind_i | input | 2 | Kind of the conflicting request |
| proc_state_valid_i | input | 1 | Processor coherency state response |
| proc_state_i | input | 2 | State given by the processor |
| pending_o | output | 1 | A processor request is outstanding |
| busy_o | output | 1 | A forwarded resolution is in progress |
| direct_valid_o | output | 1 | Direct answer to the external requestor |
| direct_state_o | output | 2 | State in the direct answer |
| fwd_valid_o | output | 1 | Conflict forwarded to the processor |
| fwd_kind_o | output | 2 | Kind of the forwarded conflict |
| ack_o | output | 1 | Completion acknowledgement for a forwarded conflict |
| proto_err_o | output | 1 | Retire or state-response rule broken |

## Verification
Some properties are checked on every cycle. An acknowledgement never comes without a state response in the cycle before it. Direct answers and forwards are never issued together. A forward always moves on to waiting for the state. A forbidden plain-ACK retire always raises the error, and a conflict that arrives with nothing pending leaves the block silent. Other behaviours only the directed scenarios can show: the exact state for each pair of pending kind and conflict kind, that a late processor response really delays the acknowledgement, the forced-forward expectations, and that conflicts arriving during a forward are dropped.

// File: rtl/ccr_pkg.sv
package ccr_pkg;
   localparam logic [1:0] PK_READ = 2'b01;
   localparam logic [1:0] PK_UPG  = 2'b10;
   localparam logic [1:0] CF_NONE = 2'b00;
   localparam logic [1:0] CF_ISH  = 2'b01;
   localparam logic [1:0] CF_IEX  = 2'b10;
   localparam logic [1:0] CF_INV  = 2'b11;
   localparam logic [1:0] BS_INV  = 2'b00;
   localparam logic [1:0] BS_SHD  = 2'b01;

   typedef enum logic [2:0] {
      S_IDLE = 3'd0,
      S_FWD  = 3'd1,
      S_WAIT = 3'd2,
      S_ACK  = 3'd3,
      S_DONE = 3'd4
   } fsm_t;
endpackage

// File: rtl/ccr_decide.sv
module ccr_decide
   import ccr_pkg::*;
#(
   parameter int KIND_W     = 2,
   parameter int STATE_W    = 2,
   parameter bit FWD_OPT_EN = 1'b1
) (
   input  logic [KIND_W-1:0]  pend_kind,
   input  logic [KIND_W-1:0]  cf_kind,
   input  logic               force_fwd,
   output logic               do_fwd,
   output logic               must_fwd,
   output logic [STATE_W-1:0] direct_state
);
   logic is_upg;
   logic force_q;

   assign is_upg   = (pend_kind == KIND_W'(PK_UPG));
   // mandatory forward: upgrade hit by exclusive intervention or invalidate
   assign must_fwd = is_upg && (cf_kind != KIND_W'(CF_ISH));

   generate
      if (FWD_OPT_EN) begin : g_opt
         assign force_q = force_fwd;
      end else begin : g_noopt
         logic unused_force;
         assign unused_force = force_fwd;
         assign force_q      = 1'b0;
      end
   endgenerate

   assign do_fwd       = must_fwd || force_q;
   assign direct_state = is_upg ? STATE_W'(BS_SHD) : STATE_W'(BS_INV);
endmodule

// File: rtl/ccr_fwd_fsm.sv
module ccr_fwd_fsm
   import ccr_pkg::*;
#(
   parameter int KIND_W  = 2,
   parameter int STATE_W = 2
) (
   input  logic               clk,
   input  logic               rst_n,
   input  logic               start,
   input  logic [KIND_W-1:0]  cf_kind,
   input  logic [KIND_W-1:0]  pend_kind,
   input  logic               st_valid,
   input  logic [STATE_W-1:0] st_val,
   output logic               idle,
   output logic               fwd_valid,
   output logic [KIND_W-1:0]  fwd_kind,
   output logic               ack,
   output logic               state_err
);
   fsm_t               st_q, st_d;
   logic [KIND_W-1:0]  cf_q;
   logic [KIND_W-1:0]  pk_q;
   logic [STATE_W-1:0] exp_state;

   always_comb begin
      st_d = st_q;
      unique case (st_q)
         S_IDLE: if (start)    st_d = S_FWD;
         S_FWD:                st_d = S_WAIT;
         S_WAIT: if (st_valid) st_d = S_ACK;
         S_ACK:                st_d = S_DONE;
         S_DONE:               st_d = S_IDLE;
         default:              st_d = S_IDLE;
      endcase
   end

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         st_q <= S_IDLE;
         cf_q <= '0;
         pk_q <= '0;
      end else begin
         st_q <= st_d;
         if (st_q == S_IDLE && start) begin
            cf_q <= cf_kind;
            pk_q <= pend_kind;
         end
      end
   end

   assign exp_state = (pk_q == KIND_W'(PK_READ)) ? STATE_W'(BS_INV) : STATE_W'(BS_SHD);
   assign idle      = (st_q == S_IDLE);
   assign fwd_valid = (st_q == S_FWD);
   assign fwd_kind  = fwd_valid ? cf_q : '0;
   assign ack       = (st_q == S_ACK);
   assign state_err = (st_q == S_WAIT) && st_valid && (st_val != exp_state);

   // R4
   fwd_then_wait_chk: assert property (@(posedge clk) disable iff (!rst_n)
      fwd_valid |=> (st_q == S_WAIT));
   // R5
   ack_after_state_chk: assert property (@(posedge clk) disable iff (!rst_n)
      ack |-> $past(st_valid));
endmodule

// File: rtl/ccr_pending.sv
module ccr_pending
   import ccr_pkg::*;
#(
   parameter int KIND_W = 2
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              pend_valid,
   input  logic [KIND_W-1:0] pend_kind,
   input  logic              retire_valid,
   input  logic              retire_data,
   input  logic              set_flag,
   input  logic              busy,
   input  logic              state_err,
   output logic              active,
   output logic [KIND_W-1:0] kind,
   output logic              proto_err
);
   logic flag_q;
   logic retire;
   logic bad_retire;

   assign retire     = retire_valid && active;
   assign bad_retire = retire && ((flag_q && !retire_data) || busy);

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         active    <= 1'b0;
         kind      <= '0;
         flag_q    <= 1'b0;
         proto_err <= 1'b0;
      end else begin
         proto_err <= bad_retire || state_err;
         if (retire) begin
            active <= 1'b0;
            flag_q <= 1'b0;
         end else begin
            if (!active && pend_valid &&
                (pend_kind == KIND_W'(PK_READ) || pend_kind == KIND_W'(PK_UPG))) begin
               active <= 1'b1;
               kind   <= pend_kind;
            end
            if (set_flag) flag_q <= 1'b1;
         end
      end
   end

   // R6
   plain_ack_err_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (flag_q && retire_valid && active && !retire_data) |=> proto_err);
   // R10
   retire_clears_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (retire_valid && active) |=> !active);
endmodule

// File: rtl/ccr_resolver.sv
module ccr_resolver
   import ccr_pkg::*;
#(
   parameter int KIND_W     = 2,
   parameter int STATE_W    = 2,
   parameter bit FWD_OPT_EN = 1'b1
) (
   input  logic               clk,
   input  logic               rst_n,
   input  logic               force_fwd_i,
   input  logic               pend_valid_i,
   input  logic [KIND_W-1:0]  pend_kind_i,
   input  logic               retire_valid_i,
   input  logic               retire_data_i,
   input  logic               cf_valid_i,
   input  logic [KIND_W-1:0]  cf_kind_i,
   input  logic               proc_state_valid_i,
   input  logic [STATE_W-1:0] proc_state_i,
   output logic               pending_o,
   output logic               busy_o,
   output logic               direct_valid_o,
   output logic [STATE_W-1:0] direct_state_o,
   output logic               fwd_valid_o,
   output logic [KIND_W-1:0]  fwd_kind_o,
   output logic               ack_o,
   output logic               proto_err_o
);
   generate
      if (KIND_W != 2) begin : g_bad_kind
         $error("ccr_resolver: KIND_W must be 2");
      end
      if (STATE_W < 1) begin : g_bad_state
         $error("ccr_resolver: STATE_W must be at least 1");
      end
   endgenerate

   logic               active;
   logic [KIND_W-1:0]  pk;
   logic               idle;
   logic               accept;
   logic               do_fwd;
   logic               must_fwd;
   logic [STATE_W-1:0] dstate;
   logic               state_err;
   logic               dir_v_q;
   logic [STATE_W-1:0] dir_s_q;

   assign accept = cf_valid_i && (cf_kind_i != KIND_W'(CF_NONE)) && active && idle;

   ccr_decide #(.KIND_W(KIND_W), .STATE_W(STATE_W), .FWD_OPT_EN(FWD_OPT_EN)) u_decide (
      .pend_kind    (pk),
      .cf_kind      (cf_kind_i),
      .force_fwd    (force_fwd_i),
      .do_fwd       (do_fwd),
      .must_fwd     (must_fwd),
      .direct_state (dstate)
   );

   ccr_pending #(.KIND_W(KIND_W)) u_pending (
      .clk          (clk),
      .rst_n        (rst_n),
      .pend_valid   (pend_valid_i),
      .pend_kind    (pend_kind_i),
      .retire_valid (retire_valid_i),
      .retire_data  (retire_data_i),
      .set_flag     (accept && must_fwd),
      .busy         (!idle),
      .state_err    (state_err),
      .active       (active),
      .kind         (pk),
      .proto_err    (proto_err_o)
   );

   ccr_fwd_fsm #(.KIND_W(KIND_W), .STATE_W(STATE_W)) u_fsm (
      .clk       (clk),
      .rst_n     (rst_n),
      .start     (accept && do_fwd),
      .cf_kind   (cf_kind_i),
      .pend_kind (pk),
      .st_valid  (proc_state_valid_i),
      .st_val    (proc_state_i),
      .idle      (idle),
      .fwd_valid (fwd_valid_o),
      .fwd_kind  (fwd_kind_o),
      .ack       (ack_o),
      .state_err (state_err)
   );

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         dir_v_q <= 1'b0;
         dir_s_q <= '0;
      end else begin
         dir_v_q <= accept && !do_fwd;
         dir_s_q <= (accept && !do_fwd) ? dstate : '0;
      end
   end

   assign direct_valid_o = dir_v_q;
   assign direct_state_o = dir_s_q;
   assign pending_o      = active;
   assign busy_o         = !idle;

   // R4
   no_dual_path_chk: assert property (@(posedge clk) disable iff (!rst_n)
      !(direct_valid_o && fwd_valid_o));
   // R8
   no_pend_silent_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (cf_valid_i && !active && idle) |=> (!direct_valid_o && !busy_o));
   // R3
   upg_direct_shared_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (accept && !do_fwd && pk == KIND_W'(PK_UPG)) |=> (direct_state_o == STATE_W'(BS_SHD)));
endmodule

// File: tb/ccr_resolver_bench.sv
module ccr_resolver_bench;
   logic       clk = 1'b0;
   logic       rst_n = 1'b0;
   logic       force_fwd = 1'b0;
   logic       pend_valid = 1'b0;
   logic [1:0] pend_kind = 2'b00;
   logic       retire_valid = 1'b0;
   logic       retire_data = 1'b0;
   logic       cf_valid = 1'b0;
   logic [1:0] cf_kind = 2'b00;
   logic       st_valid = 1'b0;
   logic [1:0] st_val = 2'b00;
   logic       pending, busy, dv, fv, ack, perr;
   logic [1:0] ds, fk;

   int checks = 0;
   int fails  = 0;
   bit ended  = 0;

   always #10 clk = ~clk;

   ccr_resolver u_ccr_resolver (
      .clk(clk), .rst_n(rst_n), .force_fwd_i(force_fwd),
      .pend_valid_i(pend_valid), .pend_kind_i(pend_kind),
      .retire_valid_i(retire_valid), .retire_data_i(retire_data),
      .cf_valid_i(cf_valid), .cf_kind_i(cf_kind),
      .proc_state_valid_i(st_valid), .proc_state_i(st_val),
      .pending_o(pending), .busy_o(busy),
      .direct_valid_o(dv), .direct_state_o(ds),
      .fwd_valid_o(fv), .fwd_kind_o(fk),
      .ack_o(ack), .proto_err_o(perr)
   );

   task automatic check(input string req, input int act, input int exp);
      checks++;
      if (act != exp) begin
         fails++;
         $display("FAIL %s: actual %0d expected %0d", req, act, exp);
      end
   endtask

   task automatic tick();
      @(negedge clk);
   endtask

   task automatic finish_run();
      if (!ended) begin
         ended = 1;
         $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
         $finish;
      end
   endtask

   task automatic issue(input logic [1:0] k);
      pend_valid = 1'b1; pend_kind = k;
      tick();
      pend_valid = 1'b0; pend_kind = 2'b00;
      check("R10 pending after issue", pending, 1);
   endtask

   task automatic retire(input logic data, input int exp_err, input string req);
      retire_valid = 1'b1; retire_data = data;
      tick();
      retire_valid = 1'b0; retire_data = 1'b0;
      check(req, perr, exp_err);
      check("R10 pending cleared", pending, 0);
   endtask

   task automatic conflict(input logic [1:0] k);
      cf_valid = 1'b1; cf_kind = k;
      tick();
      cf_valid = 1'b0; cf_kind = 2'b00;
   endtask

   // forwarded path: forward seen now; state response after extra delay
   task automatic run_forward(input logic [1:0] k, input logic [1:0] st,
                              input int delay, input int exp_err, input string req);
      check({req, " fwd_valid"}, fv, 1);
      check({req, " fwd_kind"}, fk, k);
      check({req, " no direct"}, dv, 0);
      tick();
      check({req, " fwd one cycle"}, fv, 0);
      for (int i = 0; i < delay; i++) begin
         check("R5 no ack before state", ack, 0);
         tick();
      end
      st_valid = 1'b1; st_val = st;
      tick();
      st_valid = 1'b0; st_val = 2'b00;
      check("R5 ack after state", ack, 1);
      check({req, " state error"}, perr, exp_err);
      tick();
      check("R5 ack single", ack, 0);
      tick();
      check("R9 back to idle", busy, 0);
   endtask

   task automatic t_reset();
      rst_n = 1'b0;
      repeat (3) tick();
      check("R1 reset pending", pending, 0);
      check("R1 reset busy", busy, 0);
      check("R1 reset direct", dv, 0);
      check("R1 reset fwd", fv, 0);
      check("R1 reset ack", ack, 0);
      check("R1 reset err", perr, 0);
      rst_n = 1'b1;
      tick();
   endtask

   task automatic t_read_direct(input logic [1:0] k);
      issue(2'b01);
      conflict(k);
      check("R2 direct valid", dv, 1);
      check("R2 direct Invalid", ds, 0);
      check("R2 no forward", fv, 0);
      check("R2 not busy", busy, 0);
      tick();
      check("R2 one cycle", dv, 0);
      retire(1'b0, 0, "R2 read retire ok");
   endtask

   task automatic t_upg_ish();
      issue(2'b10);
      conflict(2'b01);
      check("R3 direct valid", dv, 1);
      check("R3 direct Shared", ds, 1);
      check("R3 no forward", fv, 0);
      tick();
      retire(1'b0, 0, "R3 plain ack allowed");
   endtask

   task automatic t_upg_fwd(input logic [1:0] k, input logic data);
      issue(2'b10);
      conflict(k);
      run_forward(k, 2'b01, 3, 0, "R4");
      retire(data, data ? 0 : 1, "R6 retire rule");
   endtask

   task automatic t_no_pending();
      conflict(2'b11);
      check("R8 no direct", dv, 0);
      check("R8 no forward", fv, 0);
      check("R8 not busy", busy, 0);
      tick();
      check("R8 still quiet", dv | fv | busy | ack, 0);
   endtask

   task automatic t_forced();
      force_fwd = 1'b1;
      issue(2'b01);
      conflict(2'b01);
      run_forward(2'b01, 2'b00, 1, 0, "R7 read forced");
      retire(1'b0, 0, "R7 read plain ack ok");
      issue(2'b10);
      conflict(2'b01);
      run_forward(2'b01, 2'b01, 0, 0, "R7 upg forced");
      retire(1'b0, 0, "R7 upg ish plain ack ok");
      issue(2'b01);
      conflict(2'b10);
      run_forward(2'b10, 2'b01, 0, 1, "R7 mismatch");
      retire(1'b1, 0, "R7 retire after mismatch");
      force_fwd = 1'b0;
   endtask

   task automatic t_busy_rules();
      issue(2'b10);
      conflict(2'b11);
      check("R9 forwarded", fv, 1);
      tick();
      conflict(2'b01);
      check("R9 second conflict no direct", dv, 0);
      check("R9 second conflict no fwd", fv, 0);
      retire_valid = 1'b1; retire_data = 1'b1;
      tick();
      retire_valid = 1'b0; retire_data = 1'b0;
      check("R10 retire while busy err", perr, 1);
      st_valid = 1'b1; st_val = 2'b01;
      tick();
      st_valid = 1'b0;
      check("R5 ack", ack, 1);
      repeat (2) tick();
      check("R9 idle again", busy, 0);
      check("R9 no extra forward", fv, 0);
   endtask

   initial begin
      #(20 * 150000);
      fails++;
      $display("FAIL watchdog: actual timeout expected completion");
      finish_run();
   end

   initial begin
      tick();
      t_reset();
      t_read_direct(2'b01);
      t_read_direct(2'b10);
      t_read_direct(2'b11);
      t_upg_ish();
      t_upg_fwd(2'b10, 1'b0);
      t_upg_fwd(2'b11, 1'b1);
      t_no_pending();
      t_forced();
      t_busy_rules();
      repeat (2) tick();
      finish_run();
   end
endmodule